// File: doc/BRIEF.md
# Delay-Line Sampling-Phase Load Sequencer

This block programs a new sampling phase into the control word of a tuneable delay line. A start pulse and a 4-bit binary phase set off a fixed sequence of register updates. First the clock output and clock-data recovery are taken off, and the external phase select and the delay line are switched on. Next comes a timed wait for the line to report its clock output as disabled. The phase is then written as a reflected Gray code, and the clock output is enabled again. A second timed wait follows until the line reports the clock output as running. Last, clock-data recovery is handed back. Each wait counts 1 us ticks and gives up after a set number of them.

The control word is driven as individual bit fields and also as a packed word, so a neighbouring register file can pick up the bits at fixed positions. When the block is idle, a separate request can switch clock-data recovery on or off without touching any other field.

Top module: `dll_phase_seq`

## Requirements
- R1: While reset is held and right after it, every control field, the packed word, `done_o` and `err_o` are 0.
- R2: In the cycle after an accepted start, the preparation step is visible: delay-line enable is 1, external-select enable is 1, CDR enable is 0 and clock-output enable is 0.
- R3: The phase field changes only after a readback of 0 has been seen while clock-output enable is 0. It holds the Gray code of the phase (inputs 0..15 give 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8). In the packed word, delay-line enable sits at bit 16, CDR enable at bit 17, clock-output enable at bit 18, external-select enable at bit 19 and the phase field at bits 23:20. All other bits are 0.
- R4: Once the phase is written, clock-output enable goes to 1 while the phase stays put, and the sequencer then waits for a readback of 1.
- R5: On a readback of 1 the sequence ends with CDR enable 1 and external-select enable 0, and `done_o` pulses in the same cycle.
- R6: In either wait, the 50th tick that arrives without a matching readback aborts the sequence. `err_o` pulses, the fields keep their values, and the block returns to idle. A matching readback beats a tick that lands in the same cycle.
- R7: `done_o` and `err_o` are single-cycle pulses and are never high together.
- R8: A start that arrives while a sequence is running is ignored. The running phase and its outcome are unchanged.
- R9: In idle, a CDR toggle request writes only the CDR enable bit, using the requested value. The request is ignored while busy. A start in the same cycle takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a phase load |
| phase_i | input | 4 | Binary phase to load |
| clk_out_rb_i | input | 1 | Clock-output-enable readback from the delay line |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| cdr_req_i | input | 1 | CDR toggle request |
| cdr_req_val_i | input | 1 | Value for CDR enable on a toggle request |
| dll_en_o | output | 1 | Delay-line enable |
| cdr_en_o | output | 1 | Clock-data recovery enable |
| ext_sel_en_o | output | 1 | External phase select enable |
| clk_out_en_o | output | 1 | Clock-output enable |
| phase_field_o | output | 4 | Encoded external phase field |
| ctrl_word_o | output | 32 | Packed control word |
| done_o | output | 1 | Sequence completed pulse |
| err_o | output | 1 | Timeout abort pulse |

## Verification
Two events can land in the same cycle. One is a start meeting a CDR toggle request. The other is a start arriving in the middle of a running sequence. The bench drives a start together with a toggle request that asks for CDR enable 1. One cycle later it expects the preparation fields, with CDR enable at 0. It also fires a second start with a different phase during a long wait. The judge is the phase field and the single error pulse at the end: both must belong to the first request.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_OFF = 2'd1,
      ST_ARM      = 2'd2,
      ST_WAIT_ON  = 2'd3
   } dps_state_e;

   typedef struct packed {
      logic prep;
      logic load;
      logic arm;
      logic finish;
      logic tog;
   } dps_cmd_t;

endpackage

// File: rtl/dps_code_conv.sv
module dps_code_conv #(
   parameter int W        = 4,
   parameter bit USE_GRAY = 1'b1
) (
   input  logic [W-1:0] bin_i,
   output logic [W-1:0] code_o
);
   generate
      if (USE_GRAY) begin : g_gray
         always_comb begin
            code_o[W-1] = bin_i[W-1];
            for (int b = 0; b < W-1; b++) begin
               code_o[b] = bin_i[b] ^ bin_i[b+1];
            end
         end
      end else begin : g_bin
         assign code_o = bin_i;
      end
   endgenerate
endmodule

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic tick_i,
   output logic expired_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign expired_o = active_i && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active_i || expired_o) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
   import dps_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     rb_i,
   input  logic     expired_i,
   input  logic     tog_req_i,
   output dps_cmd_t cmd_o,
   output logic     wait_o,
   output logic     done_o,
   output logic     err_o
);
   dps_state_e st_q, st_d;
   logic       fail;

   always_comb begin
      st_d  = st_q;
      cmd_o = '0;
      fail  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               cmd_o.prep = 1'b1;
               st_d       = ST_WAIT_OFF;
            end else if (tog_req_i) begin
               cmd_o.tog = 1'b1;
            end
         end
         ST_WAIT_OFF: begin
            if (!rb_i) begin
               cmd_o.load = 1'b1;
               st_d       = ST_ARM;
            end else if (expired_i) begin
               fail = 1'b1;
               st_d = ST_IDLE;
            end
         end
         ST_ARM: begin
            cmd_o.arm = 1'b1;
            st_d      = ST_WAIT_ON;
         end
         ST_WAIT_ON: begin
            if (rb_i) begin
               cmd_o.finish = 1'b1;
               st_d         = ST_IDLE;
            end else if (expired_i) begin
               fail = 1'b1;
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign wait_o = (st_q == ST_WAIT_OFF) || (st_q == ST_WAIT_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_o <= cmd_o.finish;
         err_o  <= fail;
      end
   end
endmodule

// File: rtl/dps_ctrl_fields.sv
module dps_ctrl_fields
   import dps_pkg::*;
#(
   parameter int W        = 4,
   parameter bit USE_GRAY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  dps_cmd_t     cmd_i,
   input  logic [W-1:0] phase_i,
   input  logic         tog_val_i,
   output logic         dll_en_o,
   output logic         cdr_en_o,
   output logic         ext_en_o,
   output logic         ck_en_o,
   output logic [W-1:0] field_o
);
   logic [W-1:0] phase_q;
   logic [W-1:0] code;

   dps_code_conv #(.W(W), .USE_GRAY(USE_GRAY)) u_conv (
      .bin_i  (phase_q),
      .code_o (code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         dll_en_o <= 1'b0;
         cdr_en_o <= 1'b0;
         ext_en_o <= 1'b0;
         ck_en_o  <= 1'b0;
         field_o  <= '0;
      end else begin
         if (cmd_i.prep) begin
            phase_q  <= phase_i;
            cdr_en_o <= 1'b0;
            ck_en_o  <= 1'b0;
            ext_en_o <= 1'b1;
            dll_en_o <= 1'b1;
         end
         if (cmd_i.load) begin
            field_o <= code;
         end
         if (cmd_i.arm) begin
            ck_en_o <= 1'b1;
         end
         if (cmd_i.finish) begin
            cdr_en_o <= 1'b1;
            ext_en_o <= 1'b0;
         end
         if (cmd_i.tog) begin
            cdr_en_o <= tog_val_i;
         end
      end
   end
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
   import dps_pkg::*;
#(
   parameter int PHASE_W    = 4,
   parameter int CTRL_W     = 32,
   parameter int POLL_LIMIT = 50,
   parameter bit USE_GRAY   = 1'b1,
   parameter int POS_DLL    = 16,
   parameter int POS_CDR    = 17,
   parameter int POS_CKOUT  = 18,
   parameter int POS_EXT    = 19,
   parameter int POS_PHASE  = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               clk_out_rb_i,
   input  logic               us_tick_i,
   input  logic               cdr_req_i,
   input  logic               cdr_req_val_i,
   output logic               dll_en_o,
   output logic               cdr_en_o,
   output logic               ext_sel_en_o,
   output logic               clk_out_en_o,
   output logic [PHASE_W-1:0] phase_field_o,
   output logic [CTRL_W-1:0]  ctrl_word_o,
   output logic               done_o,
   output logic               err_o
);
   localparam int PHASE_TOP = POS_PHASE + PHASE_W - 1;

   generate
      if (PHASE_W < 1) begin : g_bad_w
         $error("PHASE_W must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_lim
         $error("POLL_LIMIT must be at least 1");
      end
      if (PHASE_TOP >= CTRL_W || POS_EXT >= CTRL_W) begin : g_bad_pos
         $error("control fields exceed CTRL_W");
      end
      if (POS_DLL == POS_CDR || POS_DLL == POS_CKOUT || POS_DLL == POS_EXT ||
          POS_CDR == POS_CKOUT || POS_CDR == POS_EXT || POS_CKOUT == POS_EXT) begin : g_bad_dup
         $error("control bit positions must differ");
      end
   endgenerate

   dps_cmd_t cmd;
   logic     waiting;
   logic     expired;

   dps_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .rb_i      (clk_out_rb_i),
      .expired_i (expired),
      .tog_req_i (cdr_req_i),
      .cmd_o     (cmd),
      .wait_o    (waiting),
      .done_o    (done_o),
      .err_o     (err_o)
   );

   dps_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (waiting),
      .tick_i    (us_tick_i),
      .expired_o (expired)
   );

   dps_ctrl_fields #(.W(PHASE_W), .USE_GRAY(USE_GRAY)) u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (cmd),
      .phase_i   (phase_i),
      .tog_val_i (cdr_req_val_i),
      .dll_en_o  (dll_en_o),
      .cdr_en_o  (cdr_en_o),
      .ext_en_o  (ext_sel_en_o),
      .ck_en_o   (clk_out_en_o),
      .field_o   (phase_field_o)
   );

   always_comb begin
      ctrl_word_o                       = '0;
      ctrl_word_o[POS_DLL]              = dll_en_o;
      ctrl_word_o[POS_CDR]              = cdr_en_o;
      ctrl_word_o[POS_CKOUT]            = clk_out_en_o;
      ctrl_word_o[POS_EXT]              = ext_sel_en_o;
      ctrl_word_o[PHASE_TOP:POS_PHASE]  = phase_field_o;
   end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int PHASE_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clk_out_rb_i,
   input logic               dll_en_o,
   input logic               cdr_en_o,
   input logic               ext_sel_en_o,
   input logic               clk_out_en_o,
   input logic [PHASE_W-1:0] phase_field_o,
   input logic               done_o,
   input logic               err_o
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !done_o && !err_o && !clk_out_en_o); // R1
   AST_PREP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_sel_en_o) |-> dll_en_o && !cdr_en_o && !clk_out_en_o); // R2
   AST_PHASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_field_o) |-> !clk_out_en_o && ext_sel_en_o && !$past(clk_out_rb_i)); // R3
   AST_ARM_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out_en_o) |-> $stable(phase_field_o) && !cdr_en_o && ext_sel_en_o); // R4
   AST_DONE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cdr_en_o && !ext_sel_en_o && clk_out_en_o && dll_en_o && $past(clk_out_rb_i)); // R5
   AST_HANDBACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_sel_en_o) |-> done_o); // R5
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R7
endmodule

bind dll_phase_seq dps_checker #(.PHASE_W(PHASE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .clk_out_rb_i  (clk_out_rb_i),
   .dll_en_o      (dll_en_o),
   .cdr_en_o      (cdr_en_o),
   .ext_sel_en_o  (ext_sel_en_o),
   .clk_out_en_o  (clk_out_en_o),
   .phase_field_o (phase_field_o),
   .done_o        (done_o),
   .err_o         (err_o)
);

// File: tb/dll_phase_seq_test.sv
module dll_phase_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  phase_i = '0;
   logic        rb;
   logic        us_tick_i = 1'b0;
   logic        cdr_req_i = 1'b0;
   logic        cdr_req_val_i = 1'b0;
   logic        dll_en_o, cdr_en_o, ext_sel_en_o, clk_out_en_o;
   logic [3:0]  phase_field_o;
   logic [31:0] ctrl_word_o;
   logic        done_o, err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int rb_dly = 0;
   int rb_mode = 0; // 0 follow, 1 stuck high, 2 stuck low
   logic [511:0] hist = '0;

   always #10 clk = ~clk;

   always_ff @(posedge clk) hist <= {hist[510:0], clk_out_en_o};
   assign rb = (rb_mode == 1) ? 1'b1 : (rb_mode == 2) ? 1'b0 : hist[rb_dly];

   dll_phase_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
      .clk_out_rb_i(rb), .us_tick_i(us_tick_i), .cdr_req_i(cdr_req_i),
      .cdr_req_val_i(cdr_req_val_i), .dll_en_o(dll_en_o), .cdr_en_o(cdr_en_o),
      .ext_sel_en_o(ext_sel_en_o), .clk_out_en_o(clk_out_en_o),
      .phase_field_o(phase_field_o), .ctrl_word_o(ctrl_word_o),
      .done_o(done_o), .err_o(err_o)
   );

   function automatic logic [3:0] exp_code(input logic [3:0] p);
      case (p)
         4'd0: return 4'h0;  4'd1: return 4'h1;  4'd2: return 4'h3;  4'd3: return 4'h2;
         4'd4: return 4'h6;  4'd5: return 4'h7;  4'd6: return 4'h5;  4'd7: return 4'h4;
         4'd8: return 4'hC;  4'd9: return 4'hD;  4'd10: return 4'hF; 4'd11: return 4'hE;
         4'd12: return 4'hA; 4'd13: return 4'hB; 4'd14: return 4'h9; default: return 4'h8;
      endcase
   endfunction

   function automatic logic [31:0] exp_word(input logic d, input logic c, input logic k,
                                            input logic e, input logic [3:0] f);
      logic [31:0] w = '0;
      w[16] = d; w[17] = c; w[18] = k; w[19] = e; w[23:20] = f;
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // mode: 0 follow readback, 1 stuck high, 2 stuck low; inject: extra start + toggle mid-run
   task automatic run_case(input logic [3:0] p, input int dly, input int mode,
                           input bit exp_err, input bit inject, input bit count_ticks);
      logic [3:0] prev = phase_field_o;
      logic [3:0] ef;
      int ticks = 0;
      bit seen = 0;
      rb_dly = dly; rb_mode = mode;
      @(negedge clk);
      start_i = 1'b1; phase_i = p; us_tick_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk(dll_en_o && ext_sel_en_o && !cdr_en_o && !clk_out_en_o, "R2 prep",
          {28'd0, dll_en_o, ext_sel_en_o, cdr_en_o, clk_out_en_o}, 32'hC);
      for (int c = 0; c < 3000; c++) begin
         if (done_o || err_o) begin seen = 1; break; end
         us_tick_i = ((c % 3) == 2);
         if (us_tick_i) ticks++;
         start_i   = inject && (c == 1);
         phase_i   = inject ? ~p : p;
         cdr_req_i = inject && (c == 6);
         cdr_req_val_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0; cdr_req_i = 1'b0;
         if (inject && c == 6)
            chk(!cdr_en_o, "R9 toggle ignored while busy", cdr_en_o, 0);
      end
      us_tick_i = 1'b0;
      chk(seen, "R6 sequence ended", seen, 1);
      chk(err_o == exp_err && done_o == !exp_err, exp_err ? "R6 error flag" : "R5 done flag",
          {done_o, err_o}, {!exp_err, exp_err});
      if (!exp_err) begin
         ef = exp_code(p);
         chk(ctrl_word_o == exp_word(1, 1, 1, 0, ef), "R3 R5 final word", ctrl_word_o,
             exp_word(1, 1, 1, 0, ef));
      end else if (mode == 2) begin
         ef = exp_code(p);
         chk(ctrl_word_o == exp_word(1, 0, 1, 1, ef), inject ? "R8 R6 late start ignored" : "R4 R6 abort on-wait",
             ctrl_word_o, exp_word(1, 0, 1, 1, ef));
      end else begin
         chk(ctrl_word_o == exp_word(1, 0, 0, 1, prev), "R6 abort off-wait keeps phase",
             ctrl_word_o, exp_word(1, 0, 0, 1, prev));
      end
      if (count_ticks) chk(ticks == 50, "R6 tick count", ticks, 50);
      @(negedge clk);
      chk(!done_o && !err_o, "R7 single pulse", {done_o, err_o}, 0);
      rb_mode = 0; rb_dly = 0;
      repeat (520) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [3:0] rp;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(ctrl_word_o == 0 && !done_o && !err_o, "R1 reset held", ctrl_word_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctrl_word_o == 0 && !done_o && !err_o, "R1 after reset", ctrl_word_o, 0);

      // R9 toggle in idle
      cdr_req_i = 1'b1; cdr_req_val_i = 1'b1;
      @(negedge clk); cdr_req_i = 1'b0;
      chk(ctrl_word_o == exp_word(0, 1, 0, 0, 0), "R9 toggle on", ctrl_word_o, exp_word(0, 1, 0, 0, 0));

      // directed phases
      run_case(4'd0, 0, 0, 0, 0, 0);
      run_case(4'd15, 3, 0, 0, 0, 0);
      run_case(4'd10, 7, 0, 0, 0, 0);

      // R9 toggle off in idle leaves others
      @(negedge clk); cdr_req_i = 1'b1; cdr_req_val_i = 1'b0;
      @(negedge clk); cdr_req_i = 1'b0;
      chk(ctrl_word_o == exp_word(1, 0, 1, 0, exp_code(4'd10)), "R9 toggle off",
          ctrl_word_o, exp_word(1, 0, 1, 0, exp_code(4'd10)));

      // R9 start and toggle in same cycle: start wins
      rb_dly = 2;
      start_i = 1'b1; phase_i = 4'd5; cdr_req_i = 1'b1; cdr_req_val_i = 1'b1;
      @(negedge clk); start_i = 1'b0; cdr_req_i = 1'b0;
      chk(!cdr_en_o && ext_sel_en_o && !clk_out_en_o, "R9 start beats toggle",
          {cdr_en_o, ext_sel_en_o, clk_out_en_o}, 3'b010);
      repeat (40) @(negedge clk);
      chk(phase_field_o == exp_code(4'd5) && cdr_en_o, "R3 R9 start completed",
          phase_field_o, exp_code(4'd5));
      rb_dly = 0;

      // timeouts
      run_case(4'd6, 0, 1, 1, 0, 1);    // readback stuck high: off-wait expires
      run_case(4'd9, 0, 2, 1, 1, 0);    // stuck low with late start and toggle
      run_case(4'd3, 0, 0, 0, 0, 0);
      run_case(4'd12, 400, 0, 1, 0, 0); // slow readback after enabled output

      for (int i = 0; i < 16; i++) begin
         rp = 4'($urandom_range(0, 15));
         run_case(rp, $urandom_range(0, 20), 0, 0, 0, 0);
      end
      summary();
   end
endmodule